// File: doc/BRIEF.md
# Backward Deduction Engine for an Array Multiplier

This block takes the product of an N-by-N ripple-carry array multiplier as fixed and works back towards the operands. Every wire of the array holds a three-valued trit: zero, one or unknown. The array's internal sum and carry wires start out unknown. The operands are loaded from two trit vectors. For factoring, these are all unknown. If some or all of the operand bits are known, the engine can also check a product forward.

After a start pulse, the engine evaluates one array cell per clock cycle. It visits the cells row by row, with the column index stepping fastest inside each row. For each cell it finds every assignment of the cell's terminals that is consistent with the trits already known. Any terminal on which all of those assignments agree is resolved and written back. Passes over the whole array repeat until a complete pass changes nothing. If a cell has no consistent assignment at all, the engine stops with an error.

The operand trits are always visible on the outputs. The internal sum and carry trits are visible too, so the result can be checked.

The state machine has three states:
- `ST_IDLE` waits after reset. The transition "start" leads to `ST_EVAL`.
- `ST_EVAL` evaluates one cell per cycle.
  - The transition "contradiction" leads to `ST_DONE` with the error flag set.
  - The transition "quiet pass" leads to `ST_DONE` when the last cell of a pass completes a pass with no change, or when the pass cap is reached.
  - Otherwise the engine stays in `ST_EVAL`.
- `ST_DONE` holds all results. The transition "restart" leads back to `ST_EVAL` on a new start pulse.

Top module: `revmul_engine`

## Requirements
- R1: Trits are 2 bits wide: 2'b00 is zero, 2'b01 is one, 2'b10 is unknown. Trit k of a flat vector sits at bits [2k+1:2k]. After reset the engine is idle, with `busy`=0, `done`=0 and `error`=0, and every operand trit reads unknown.
- R2: A start pulse in `ST_IDLE` or `ST_DONE` does the following:
  - It loads the operand trits from `a_init` and `b_init`.
  - It sets every internal sum trit S[r][c] and carry trit C[r][c] to unknown.
  - It then ties the product bits: S[r][0] = P[r] for each row r, S[N-1][c] = P[N-1+c], and C[N-1][N-1] = P[2N-1].
  - It clears `error`, and `busy` rises on the next cycle.
  - Flat internal vectors place S[r][c] (or C[r][c]) at trit index r*N+c.
  - Operands that are fully known stay unchanged through the run.
- R3: Cell (r,c) adds A[c]&B[r], a sum-in and a carry-in, giving S[r][c] and C[r][c]. Its sum-in and carry-in come from these places:
  - Sum-in is 0 in row 0. Otherwise it is C[r-1][N-1] when c=N-1, and S[r-1][c+1] for other columns.
  - Carry-in is 0 in column 0, and C[r][c-1] otherwise.
  - Cells are evaluated one per cycle, in row-major order. With both operands known and a matching product, a run takes exactly 2*N*N busy cycles.
- R4: A cell resolves a terminal only when every assignment of the cell's terminals that is consistent with its known trits agrees on that terminal's value. A known trit is never overwritten during a run.
- R5: If some cell has no consistent assignment, the engine sets `error` and stops in `ST_DONE`. With both operands known and a product other than A*B, this always happens.
- R6: With both operands known and product A*B, there is no error. At the end, every internal sum and carry trit equals the value the array computes.
- R7: With unknown operands and a product that has at least one factorisation into two N-bit values, there is no error. Every resolved operand trit equals that bit in every such factorisation.
- R8: With unknown operands and an odd product that has a factorisation, A[0] and B[0] resolve to one and every row-0 carry resolves to zero. This applies, for example, to 143 when N=4.
- R9: A run ends after at most 2*N*N+2*N+2 passes.
- R10: In `ST_DONE`, with no start pulse, `done` stays high and every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load and begin a run (ignored while busy) |
| product | input | 2*N | Known product bits |
| a_init | input | 2*N | Initial trits of operand A |
| b_init | input | 2*N | Initial trits of operand B |
| a_trits | output | 2*N | Deduced trits of operand A |
| b_trits | output | 2*N | Deduced trits of operand B |
| sum_trits | output | 2*N*N | Internal sum trits S[r][c] |
| carry_trits | output | 2*N*N | Internal carry trits C[r][c] |
| busy | output | 1 | High in `ST_EVAL` |
| done | output | 1 | High in `ST_DONE` |
| error | output | 1 | A contradiction stopped the run |

## Verification
The bench builds the engine with N=4. At that size all 256 operand pairs and all 256 eight-bit products can be swept in full.

- **Forward runs.** Known operands are run with the correct product. Each run is checked for run length and for the value of every internal trit. Known operands are also run with a product off by one, which must raise the error.
- **Reverse runs.** Every product is run with unknown operands. Each resolved operand trit is checked against the complete list of factorisations the bench computes by multiplication.

// File: rtl/revmul_pkg.sv
package revmul_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T0 = 2'b00;
    localparam trit_t T1 = 2'b01;
    localparam trit_t TX = 2'b10;

    // terminal slots of one array cell
    localparam int TA  = 0;
    localparam int TB  = 1;
    localparam int TSI = 2;
    localparam int TCI = 3;
    localparam int TSO = 4;
    localparam int TCO = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DONE} st_e;

    // all six terminal values for one choice of the four free cell inputs
    function automatic logic [5:0] cell_combo(input logic [3:0] k);
        logic pp, s, c;
        pp = k[0] & k[1];
        s  = pp ^ k[2] ^ k[3];
        c  = (pp & k[2]) | (pp & k[3]) | (k[2] & k[3]);
        return {c, s, k[3], k[2], k[1], k[0]};
    endfunction

endpackage

// File: rtl/revmul_cell.sv
module revmul_cell
    import revmul_pkg::*;
(
    input  trit_t [5:0] term_in,
    output trit_t [5:0] term_out,
    output logic        cell_err,
    output logic        cell_chg
);

    logic [5:0] seen0, seen1;

    always_comb begin
        seen0 = '0;
        seen1 = '0;
        for (int k = 0; k < 16; k++) begin
            logic [5:0] v;
            logic       fits;
            v    = cell_combo(4'(k));
            fits = 1'b1;
            for (int t = 0; t < 6; t++) begin
                if (term_in[t] != TX && term_in[t][0] != v[t]) fits = 1'b0;
            end
            if (fits) begin
                seen1 = seen1 | v;
                seen0 = seen0 | ~v;
            end
        end
    end

    always_comb begin
        for (int t = 0; t < 6; t++) begin
            if (seen1[t] && !seen0[t])      term_out[t] = T1;
            else if (seen0[t] && !seen1[t]) term_out[t] = T0;
            else                            term_out[t] = TX;
        end
        cell_err = ~|(seen0 | seen1);
        cell_chg = !cell_err && (term_out != term_in);
    end

    always_comb begin
        for (int t = 0; t < 6; t++) begin
            if (!cell_err && term_in[t] != TX)
                AST_REFINE_ONLY: assert (term_out[t] == term_in[t]); // R4
        end
    end

endmodule

// File: rtl/revmul_scan.sv
module revmul_scan #(
    parameter int N   = 4,
    parameter int CAP = 42
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          step,
    output logic [((N>1)?$clog2(N):1)-1:0] row,
    output logic [((N>1)?$clog2(N):1)-1:0] col,
    output logic [$clog2(CAP+1)-1:0]      sweep,
    output logic                          last_cell
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    assign last_cell = (row == LAST) && (col == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row   <= '0;
            col   <= '0;
            sweep <= '0;
        end else if (clear) begin
            row   <= '0;
            col   <= '0;
            sweep <= '0;
        end else if (step) begin
            if (col == LAST) begin
                col <= '0;
                if (row == LAST) begin
                    row   <= '0;
                    sweep <= sweep + 1'b1;
                end else begin
                    row <= row + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/revmul_engine.sv
module revmul_engine
    import revmul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2*N-1:0]   product,
    input  logic [2*N-1:0]   a_init,
    input  logic [2*N-1:0]   b_init,
    output logic [2*N-1:0]   a_trits,
    output logic [2*N-1:0]   b_trits,
    output logic [2*N*N-1:0] sum_trits,
    output logic [2*N*N-1:0] carry_trits,
    output logic             busy,
    output logic             done,
    output logic             error
);

    localparam int IW  = (N > 1) ? $clog2(N) : 1;
    localparam int CAP = 2*N*N + 2*N + 2;
    localparam int SW  = $clog2(CAP + 1);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    st_e st_q, st_d;

    trit_t [N-1:0]         a_q, b_q;
    trit_t [N-1:0][N-1:0]  s_q, c_q, s_init, c_init;
    logic                  err_q, chg_q;

    logic [IW-1:0] row, col, rm1, cp1, cm1;
    logic [SW-1:0] sweep;
    logic          last_cell, load, step;

    trit_t [5:0] term_in, term_out;
    logic        cell_err, cell_chg;

    assign load = start && (st_q != ST_EVAL);
    assign step = (st_q == ST_EVAL) && !cell_err;

    revmul_scan #(.N(N), .CAP(CAP)) u_scan (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
        .row(row), .col(col), .sweep(sweep), .last_cell(last_cell)
    );

    // neighbour indices, clamped so that unused selections stay in range
    always_comb begin
        rm1 = (row == '0) ? '0 : row - 1'b1;
        cp1 = (col == LAST) ? col : col + 1'b1;
        cm1 = (col == '0) ? '0 : col - 1'b1;
    end

    always_comb begin
        term_in[TA]  = a_q[col];
        term_in[TB]  = b_q[row];
        if (row == '0)        term_in[TSI] = T0;
        else if (col == LAST) term_in[TSI] = c_q[rm1][N-1];
        else                  term_in[TSI] = s_q[rm1][cp1];
        term_in[TCI] = (col == '0) ? T0 : c_q[row][cm1];
        term_in[TSO] = s_q[row][col];
        term_in[TCO] = c_q[row][col];
    end

    revmul_cell u_cell (
        .term_in(term_in), .term_out(term_out),
        .cell_err(cell_err), .cell_chg(cell_chg)
    );

    // start image of the internal wires with the product tied in
    always_comb begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                s_init[r][c] = TX;
                c_init[r][c] = TX;
            end
        end
        for (int r = 0; r < N; r++) s_init[r][0] = {1'b0, product[r]};
        for (int c = 0; c < N; c++) s_init[N-1][c] = {1'b0, product[N-1+c]};
        c_init[N-1][N-1] = {1'b0, product[2*N-1]};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_EVAL;
            ST_EVAL: begin
                if (cell_err)
                    st_d = ST_DONE;
                else if (last_cell && (!(chg_q || cell_chg) || sweep == SW'(CAP - 1)))
                    st_d = ST_DONE;
            end
            ST_DONE: if (start) st_d = ST_EVAL;
            default: st_d = ST_IDLE;
        endcase
    end

    // trit store and write-back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                a_q[i] <= TX;
                b_q[i] <= TX;
            end
            s_q   <= '0;
            c_q   <= '0;
            err_q <= 1'b0;
            chg_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < N; i++) begin
                a_q[i] <= a_init[2*i +: 2];
                b_q[i] <= b_init[2*i +: 2];
            end
            s_q   <= s_init;
            c_q   <= c_init;
            err_q <= 1'b0;
            chg_q <= 1'b0;
        end else if (st_q == ST_EVAL) begin
            if (cell_err) begin
                err_q <= 1'b1;
            end else begin
                a_q[col]      <= term_out[TA];
                b_q[row]      <= term_out[TB];
                s_q[row][col] <= term_out[TSO];
                c_q[row][col] <= term_out[TCO];
                if (row != '0) begin
                    if (col == LAST) c_q[rm1][N-1] <= term_out[TSI];
                    else             s_q[rm1][cp1] <= term_out[TSI];
                end
                if (col != '0) c_q[row][cm1] <= term_out[TCI];
                chg_q <= last_cell ? 1'b0 : (chg_q | cell_chg);
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (st_q == ST_EVAL);
        done        = (st_q == ST_DONE);
        error       = err_q;
        a_trits     = a_q;
        b_trits     = b_q;
        sum_trits   = s_q;
        carry_trits = c_q;
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q != ST_EVAL) |=> (busy && !error)); // R2

    AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sweep < SW'(CAP))); // R9

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cell_err) |=> (done && error)); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(a_trits) && $stable(b_trits) && $stable(error))); // R10

    for (genvar k = 0; k < N; k++) begin : g_hold
        AST_KNOWN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && $past(busy) && $past(a_q[k]) != TX) |-> (a_q[k] == $past(a_q[k]))); // R4
        AST_TRIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (a_q[k] != 2'b11) && (b_q[k] != 2'b11)); // R1
    end

endmodule

// File: tb/revmul_engine_test.sv
module revmul_engine_test;

    localparam int N = 4;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT = 2000;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             start = 0;
    logic [2*N-1:0]   product = '0, a_init = '0, b_init = '0;
    logic [2*N-1:0]   a_trits, b_trits;
    logic [2*N*N-1:0] sum_trits, carry_trits;
    logic             busy, done, error;

    int total = 0;
    int failed = 0;
    int cyc_all = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    revmul_engine #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .product(product),
        .a_init(a_init), .b_init(b_init), .a_trits(a_trits), .b_trits(b_trits),
        .sum_trits(sum_trits), .carry_trits(carry_trits),
        .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] known_vec(input int v);
        logic [2*N-1:0] r;
        for (int k = 0; k < N; k++) r[2*k +: 2] = {1'b0, v[k]};
        return r;
    endfunction

    function automatic logic [2*N-1:0] unknown_vec();
        logic [2*N-1:0] r;
        for (int k = 0; k < N; k++) r[2*k +: 2] = 2'b10;
        return r;
    endfunction

    logic [2*N*N-1:0] snap_s, snap_c;

    task automatic run(input int p, input logic [2*N-1:0] ai, input logic [2*N-1:0] bi,
                       output int cyc);
        @(negedge clk);
        product = p[2*N-1:0];
        a_init  = ai;
        b_init  = bi;
        start   = 1;
        @(negedge clk);
        start   = 0;
        snap_s  = sum_trits;
        snap_c  = carry_trits;
        cyc = 0;
        while (!done && cyc < RUN_LIMIT) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_all++;
            if (cyc_all > 190000) begin
                total++;
                failed++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 190000);
                $display("%0d/%0d checks passed", total - failed, total);
                $finish;
            end
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !error, "R1 reset flags", {busy, done, error}, 0);
        chk(a_trits == unknown_vec(), "R1 reset operand trits", a_trits, unknown_vec());
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        // forward runs: both operands known, correct product
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [2*N*N-1:0] es, ec;
                logic [N-1:0][N-1:0] ms, mc;
                run(a * b, known_vec(a), known_vec(b), cyc);
                for (int r = 0; r < N; r++) begin
                    for (int c = 0; c < N; c++) begin
                        logic pp, si, ci;
                        pp = a[c] & b[r];
                        si = (r == 0) ? 1'b0 : ((c == N-1) ? mc[r-1][N-1] : ms[r-1][c+1]);
                        ci = (c == 0) ? 1'b0 : mc[r][c-1];
                        ms[r][c] = pp ^ si ^ ci;
                        mc[r][c] = (pp & si) | (pp & ci) | (si & ci);
                        es[2*(r*N+c) +: 2] = {1'b0, ms[r][c]};
                        ec[2*(r*N+c) +: 2] = {1'b0, mc[r][c]};
                    end
                end
                chk(!error, "R6 no error forward", error, 0);
                chk(cyc == 2*N*N, "R3 run length", cyc, 2*N*N);
                chk(sum_trits == es && carry_trits == ec, "R6 internal trits",
                    sum_trits ^ es, carry_trits ^ ec);
                chk(a_trits == known_vec(a) && b_trits == known_vec(b), "R2 known operands kept",
                    {a_trits, b_trits}, {known_vec(a), known_vec(b)});
            end
        end

        // R10: results held in the done state
        run(6 * 7, known_vec(6), known_vec(7), cyc);
        repeat (4) @(negedge clk);
        chk(done && !error && a_trits == known_vec(6), "R10 done holds", {done, error}, 2);

        // R5: wrong product with known operands
        for (int a = 0; a < 16; a += 3) begin
            for (int b = 1; b < 16; b += 2) begin
                run((a * b + 1) % 256, known_vec(a), known_vec(b), cyc);
                chk(done && error, "R5 contradiction flagged", {done, error}, 3);
            end
        end

        // reverse runs over every product
        for (int p = 0; p < 256; p++) begin
            logic [N-1:0] a1, a0, b1, b0;
            logic [2*N*N-1:0] is, ic;
            bit fact;
            int bad;
            a1 = '0; a0 = '0; b1 = '0; b0 = '0; fact = 0; bad = 0;
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    if (a * b == p) begin
                        fact = 1;
                        a1 |= a[N-1:0]; a0 |= ~a[N-1:0];
                        b1 |= b[N-1:0]; b0 |= ~b[N-1:0];
                    end
                end
            end
            for (int i = 0; i < N*N; i++) begin
                is[2*i +: 2] = 2'b10;
                ic[2*i +: 2] = 2'b10;
            end
            for (int r = 0; r < N; r++) is[2*(r*N) +: 2] = {1'b0, p[r]};
            for (int c = 0; c < N; c++) is[2*((N-1)*N+c) +: 2] = {1'b0, p[N-1+c]};
            ic[2*(N*N-1) +: 2] = {1'b0, p[2*N-1]};

            run(p, unknown_vec(), unknown_vec(), cyc);
            chk(snap_s == is && snap_c == ic, "R2 start image", snap_s ^ is, snap_c ^ ic);
            chk(done, "R9 run terminates", cyc, 0);
            if (fact) begin
                chk(!error, "R7 no error on factorable product", error, 0);
                for (int k = 0; k < N; k++) begin
                    if (a_trits[2*k +: 2] == 2'b01 && a0[k]) bad++;
                    if (a_trits[2*k +: 2] == 2'b00 && a1[k]) bad++;
                    if (b_trits[2*k +: 2] == 2'b01 && b0[k]) bad++;
                    if (b_trits[2*k +: 2] == 2'b00 && b1[k]) bad++;
                end
                chk(bad == 0, "R7 resolved trits sound", bad, 0);
                if (p % 2 == 1) begin
                    int nz;
                    nz = 0;
                    for (int c = 0; c < N; c++) if (carry_trits[2*c +: 2] != 2'b00) nz++;
                    chk(a_trits[1:0] == 2'b01 && b_trits[1:0] == 2'b01, "R8 low operand bits",
                        {a_trits[1:0], b_trits[1:0]}, 4'b0101);
                    chk(nz == 0, "R8 row-0 carries zero", nz, 0);
                    if (p == 143)
                        chk(!error && a_trits[1:0] == 2'b01, "R8 product 143", a_trits, 8'hA9);
                end
            end
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule